// File: doc/BRIEF.md
# Sign-Preserving Minimum-Magnitude Combiner

This block sits after a bank of narrowband filters. On each accepted beat it takes one time-aligned sample from each of N frequency channels and scales every channel by its own gain. It then passes on the scaled value whose absolute size is the smallest, keeping that value's sign.

Clutter from grain scattering changes strongly from band to band, so in at least one band it falls close to zero and the minimum suppresses it. A real reflector looks alike in every band, so it survives the minimum. Because the sign is kept, its polarity stays available to a later classifier.

Input and output are streams. A whole record, up to 4096 samples or longer, is simply a sequence of beats. The gains come from static configuration inputs and are sampled on the same beat as the data they scale.

Top module: `minmag_combiner`

## Requirements
- R1: Channel c is normalized as floor((x * g + 2^14) / 2^15). Here x is the signed 16-bit sample in `in_data[c*16 +: 16]` and g is the unsigned Q1.15 gain in `gain[c*16 +: 16]`, so 32768 means 1.0 and halves round upward.
- R2: A normalized value is clamped to the range [-32767, +32767]. The code -32768 is therefore never output, and gains above 1.0 saturate at +32767 or -32767.
- R3: The output is the normalized channel value with the smallest absolute value.
- R4: The output carries the sign of the selected normalized value. It is never its absolute value.
- R5: When several channels share the smallest magnitude, the channel with the lowest index is selected.
- R6: With `out_ready` held high, the result of a beat accepted at clock edge k appears on `out_data` with `out_valid` high after edge k+ceil(log2 N)+1. That is ceil(log2 N)+2 register stages, which is 6 for N=12.
- R7: `in_ready` is high exactly when `out_ready` is high or `out_valid` is low. While `out_valid` is high and `out_ready` is low, the whole pipeline holds: `out_data` stays unchanged and no input is accepted.
- R8: During reset and directly after it, `out_valid` is 0 and `out_data` is 0.
- R9: The channel count N is a parameter from 1 to 16 (default 12). Channel c occupies bits `[c*16 +: 16]` of `in_data`, and both the first and the last channel take part in the selection.
- R10: Every accepted beat produces exactly one output beat, in order. Cycles with `in_valid` low produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept an input beat |
| in_data | input | NCH*DW | Channel samples, channel c at [c*DW +: DW], signed |
| gain | input | NCH*GW | Per-channel unsigned Q1.15 gains, channel c at [c*GW +: GW] |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | DW | Selected normalized sample, signed |

## Verification
The bench drives beats that place two equal magnitudes of opposite sign in different channels. A design that resolved ties toward the higher channel, or compared signed values instead of magnitudes, would return the wrong value or the wrong polarity.

Directed beats also cover several other cases:
- a full-scale negative sample at unity gain, which a design without the clamp would pass on as -32768;
- gains above 1.0 that overflow the sample range;
- odd products at half gain, where truncation would differ from rounding by one code;
- the minimum placed in the first channel and in the last channel.

Random streams with bubbles and downstream stalls compare every cycle against a behavioural model. A stall that did not freeze the pipeline would drop or duplicate beats, and an error in the valid delay line would shift results by a cycle.

// File: rtl/minmag_pkg.sv
package minmag_pkg;

   // Number of nodes left after k pairwise reduction levels starting from n
   function automatic int lvl_cnt(input int n, input int k);
      int c;
      c = n;
      for (int i = 0; i < k; i++) c = (c + 1) / 2;
      return c;
   endfunction

   // Number of reduction levels needed to bring n nodes down to one
   function automatic int lvl_depth(input int n);
      return (n > 1) ? $clog2(n) : 0;
   endfunction

endpackage

// File: rtl/minmag_norm.sv
module minmag_norm #(
   parameter int DW = 16,
   parameter int GW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic [DW-1:0]        smp_i,
   input  logic [GW-1:0]        gain_i,
   output logic signed [DW-1:0] norm_o
);
   localparam int PW   = DW + GW + 1;
   localparam int FRAC = GW - 1;
   localparam logic signed [PW-1:0] HI   = {{(GW+2){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [PW-1:0] LO   = -HI;
   localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC - 1);

   logic signed [PW-1:0] sx, gx, prod, shf;
   logic signed [DW-1:0] sat;

   always_comb begin
      sx   = {{(GW+1){smp_i[DW-1]}}, smp_i};
      gx   = {{(DW+1){1'b0}}, gain_i};
      prod = sx * gx;
      shf  = (prod + HALF) >>> FRAC;
      if (shf > HI)      sat = HI[DW-1:0];
      else if (shf < LO) sat = LO[DW-1:0];
      else               sat = shf[DW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  norm_o <= '0;
      else if (en) norm_o <= sat;
   end
endmodule

// File: rtl/minmag_tree.sv
module minmag_tree
   import minmag_pkg::*;
#(
   parameter int NCH = 12,
   parameter int DW  = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic [NCH*DW-1:0]    vals_i,
   output logic signed [DW-1:0] val_o
);
   localparam int L  = lvl_depth(NCH);
   localparam int MW = DW - 1;

   function automatic logic [MW-1:0] mag_of(input logic signed [DW-1:0] x);
      logic signed [DW-1:0] n;
      n = x[DW-1] ? -x : x;
      return n[MW-1:0];
   endfunction

   for (genvar lv = 0; lv <= L; lv++) begin : lvl
      localparam int CN = lvl_cnt(NCH, lv);
      logic signed [DW-1:0] v [CN];
      logic [MW-1:0]        m [CN];

      if (lv == 0) begin : g_leaf
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < CN; i++) begin
                  v[i] <= '0;
                  m[i] <= '0;
               end
            end else if (en) begin
               for (int i = 0; i < CN; i++) begin
                  v[i] <= vals_i[i*DW +: DW];
                  m[i] <= mag_of(vals_i[i*DW +: DW]);
               end
            end
         end
      end else begin : g_node
         localparam int PN = lvl_cnt(NCH, lv - 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < CN; i++) begin
                  v[i] <= '0;
                  m[i] <= '0;
               end
            end else if (en) begin
               for (int i = 0; i < CN; i++) begin
                  int ri;
                  ri = (2*i + 1 < PN) ? 2*i + 1 : 2*i;
                  // the right (higher index) side wins only on a strictly smaller magnitude
                  if (lvl[lv-1].m[ri] < lvl[lv-1].m[2*i]) begin
                     v[i] <= lvl[lv-1].v[ri];
                     m[i] <= lvl[lv-1].m[ri];
                  end else begin
                     v[i] <= lvl[lv-1].v[2*i];
                     m[i] <= lvl[lv-1].m[2*i];
                  end
               end
            end
         end
      end
   end

   assign val_o = lvl[L].v[0];
endmodule

// File: rtl/minmag_combiner.sv
module minmag_combiner
   import minmag_pkg::*;
#(
   parameter int NCH = 12,
   parameter int DW  = 16,
   parameter int GW  = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [NCH*DW-1:0]    in_data,
   input  logic [NCH*GW-1:0]    gain,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic signed [DW-1:0] out_data
);
   localparam int LAT = lvl_depth(NCH) + 2;

   if (NCH < 1 || NCH > 16) begin : g_bad_nch
      $error("minmag_combiner: NCH must lie in 1..16");
   end
   if (DW < 2) begin : g_bad_dw
      $error("minmag_combiner: DW must be at least 2");
   end
   if (GW < 2) begin : g_bad_gw
      $error("minmag_combiner: GW must be at least 2");
   end

   logic              en;
   logic [LAT-1:0]    vpipe;
   logic [NCH*DW-1:0] nv;

   assign en       = out_ready || !out_valid;
   assign in_ready = en;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic signed [DW-1:0] nrm;
      minmag_norm #(.DW(DW), .GW(GW)) u_norm (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (en),
         .smp_i  (in_data[ch*DW +: DW]),
         .gain_i (gain[ch*GW +: GW]),
         .norm_o (nrm)
      );
      assign nv[ch*DW +: DW] = nrm;
   end

   minmag_tree #(.NCH(NCH), .DW(DW)) u_tree (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .vals_i (nv),
      .val_o  (out_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  vpipe <= '0;
      else if (en) vpipe <= {vpipe[LAT-2:0], in_valid};
   end

   assign out_valid = vpipe[LAT-1];
endmodule

// File: rtl/minmag_chk.sv
module minmag_chk #(
   parameter int DW = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_ready,
   input logic                 out_valid,
   input logic                 out_ready,
   input logic signed [DW-1:0] out_data
);
   localparam logic signed [DW-1:0] MOSTNEG = {1'b1, {(DW-1){1'b0}}};

   // R2
   no_mostneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_data != MOSTNEG);

   // R7
   hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   // R7
   stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);

   // R7
   idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   // R8
   rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid);
endmodule

bind minmag_combiner minmag_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data)
);

// File: tb/tb_minmag_combiner.sv
module tb_minmag_combiner;
   localparam int CLK_PER = 10;
   localparam int NCH     = 12;
   localparam int DW      = 16;
   localparam int GW      = 16;
   localparam int LAT     = $clog2(NCH) + 2;
   localparam int UNITY   = 32768;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic out_ready = 1'b0;
   logic [NCH*DW-1:0] in_data = '0;
   logic [NCH*GW-1:0] gain = '0;
   logic in_ready, out_valid;
   logic signed [DW-1:0] out_data;

   int errors = 0;
   int checks = 0;
   string cur_tag = "R3";
   bit running = 1'b0;
   bit finished = 1'b0;

   minmag_combiner #(.NCH(NCH), .DW(DW), .GW(GW)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .gain(gain), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data)
   );

   always #(CLK_PER/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Requirement-level reference: normalize, clamp, smallest magnitude, lowest index on ties
   function automatic longint ref_out(input logic [NCH*DW-1:0] d, input logic [NCH*GW-1:0] g);
      longint best, bestmag;
      bestmag = 64'sd1 << 40;
      best = 0;
      for (int c = 0; c < NCH; c++) begin
         longint x, gg, p, mg;
         x  = longint'($signed(d[c*DW +: DW]));
         gg = longint'(g[c*GW +: GW]);
         p  = (x * gg + 16384) >>> 15;
         if (p > 32767)  p = 32767;
         if (p < -32767) p = -32767;
         mg = (p < 0) ? -p : p;
         if (mg < bestmag) begin
            bestmag = mg;
            best = p;
         end
      end
      return best;
   endfunction

   // Behavioural model: LAT-deep delay line that advances when the output can move
   bit     mv [LAT];
   longint md [LAT];
   string  mt [LAT];

   always @(posedge clk) begin
      bit mr;
      if (!rst_n) begin
         for (int k = 0; k < LAT; k++) begin
            mv[k] = 1'b0;
            md[k] = 0;
            mt[k] = "R10";
         end
      end else begin
         mr = out_ready || !mv[LAT-1];
         if (mr) begin
            for (int k = LAT-1; k > 0; k--) begin
               mv[k] = mv[k-1];
               md[k] = md[k-1];
               mt[k] = mt[k-1];
            end
            mv[0] = in_valid;
            md[0] = ref_out(in_data, gain);
            mt[0] = cur_tag;
         end
      end
   end

   always @(posedge clk) begin
      #(CLK_PER/4);
      if (running) begin
         chk(out_valid == mv[LAT-1], "R10 out_valid", out_valid, mv[LAT-1]);
         chk(in_ready == (out_ready || !mv[LAT-1]), "R7 in_ready", in_ready,
             out_ready || !mv[LAT-1]);
         if (out_valid && mv[LAT-1])
            chk(longint'(out_data) == md[LAT-1], mt[LAT-1], out_data, md[LAT-1]);
      end
   end

   task automatic set_ch(input int ch, input int val);
      in_data[ch*DW +: DW] = val[DW-1:0];
   endtask

   task automatic fill(input int val, input int g);
      for (int c = 0; c < NCH; c++) begin
         in_data[c*DW +: DW] = val[DW-1:0];
         gain[c*GW +: GW]    = g[GW-1:0];
      end
   endtask

   task automatic beat(input string tag);
      cur_tag = tag;
      in_valid = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      int cnt;
      logic signed [DW-1:0] held;
      repeat (3) @(negedge clk);
      // R8: reset state
      chk(out_valid == 1'b0, "R8 out_valid", out_valid, 0);
      chk(out_data == '0, "R8 out_data", out_data, 0);
      rst_n = 1'b1;
      out_ready = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 out_valid after release", out_valid, 0);
      running = 1'b1;

      // R1: rounding at half gain
      fill(1000, UNITY); set_ch(0, 3);  gain[0 +: GW] = 16'd16384; beat("R1");
      fill(1000, UNITY); set_ch(0, -3); gain[0 +: GW] = 16'd16384; beat("R1");
      fill(1000, UNITY); set_ch(0, 5);  gain[0 +: GW] = 16'd16384; beat("R1");
      fill(20000, UNITY); gain[6*GW +: GW] = '0; beat("R1");
      // R2: clamp of the most negative code and gain overflow
      fill(-32768, UNITY); beat("R2");
      fill(30000, 65535); beat("R2");
      fill(-30000, 65535); beat("R2");
      // R4: negative winner keeps its sign
      fill(500, UNITY); set_ch(5, -7); beat("R4");
      // R5: tie of opposite signs goes to the lower channel
      fill(400, UNITY); set_ch(3, 9); set_ch(8, -9); beat("R5");
      fill(400, UNITY); set_ch(3, -9); set_ch(8, 9); beat("R5");
      // R9: winner at the edges of the channel range
      fill(300, UNITY); set_ch(0, 1); beat("R9");
      fill(300, UNITY); set_ch(NCH-1, -2); beat("R9");
      in_valid = 1'b0;
      repeat (LAT + 2) @(negedge clk);

      // R6: latency of a lone beat
      fill(50, UNITY); set_ch(2, -11); cur_tag = "R6"; in_valid = 1'b1;
      @(posedge clk); #(CLK_PER/4); cnt = 1;
      @(negedge clk); in_valid = 1'b0;
      while (!out_valid && cnt < 20) begin
         @(posedge clk); #(CLK_PER/4); cnt++;
      end
      chk(cnt == LAT, "R6 latency", cnt, LAT);
      chk(out_data == -16'sd11, "R6 value", out_data, -11);
      repeat (3) @(negedge clk);

      // R7: stall holds output and blocks input
      out_ready = 1'b0;
      for (int n = 0; n < LAT + 4; n++) begin
         fill(n * 10 + 5, UNITY); set_ch(n % NCH, -n - 1); beat("R7");
      end
      held = out_data;
      @(negedge clk);
      chk(out_valid == 1'b1, "R7 held valid", out_valid, 1);
      chk(out_data == held, "R7 held data", out_data, held);
      chk(in_ready == 1'b0, "R7 ready low", in_ready, 0);
      in_valid = 1'b0;
      out_ready = 1'b1;
      repeat (LAT + 4) @(negedge clk);

      // R3 / R10: random streams with bubbles and stalls
      for (int n = 0; n < 4000; n++) begin
         for (int c = 0; c < NCH; c++) begin
            int v;
            if (n % 2 == 0) v = int'($urandom_range(0, 40)) - 20;
            else            v = int'($urandom_range(0, 65535)) - 32768;
            set_ch(c, v);
            gain[c*GW +: GW] = (n % 3 == 0) ? GW'(UNITY) : GW'($urandom_range(0, 65535));
         end
         cur_tag   = (n < 2000) ? "R3" : "R10";
         in_valid  = ($urandom_range(0, 9) < ((n < 2000) ? 7 : 3));
         out_ready = ($urandom_range(0, 9) < 8);
         @(negedge clk);
      end
      in_valid = 1'b0;
      out_ready = 1'b1;
      repeat (LAT + 4) @(negedge clk);
      running = 1'b0;
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule